// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block decodes the write-cycle command language of a dual-bank NOR-style flash device. Each write arrives as a one-cycle strobe that has already been synchronized to the clock and carries an address and a 16-bit data word. The sequencer follows the two coded unlock writes, the set-up write and any confirm writes that an instruction needs. When an instruction is complete it raises a single-cycle operation request with an operation code and the latched address and data. A write that breaks the grammar raises a single-cycle abort pulse instead.

The block also holds the current read mode (array, identification, or query table), a bypass flag that lets programs skip the unlock writes, and the 16-bit configuration word whose bit 10 enables power-down. The array, the program/erase timing engine and the voltage checks sit outside the block. Two inputs stand in for them: `busy` (an operation is running) and `suspended` (an erase is on hold). The sequencer records the block and bank of the last erase it issued. From that record it decides whether a suspend, a resume or a program issued during suspension is legal.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `read_mode` is 0 (array), `in_bypass` is 0, `cfg_word` is 0, and neither `op_valid` nor `abort_pulse` is high.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then one address/data write produce `op_valid` for one cycle with `op_kind`=1 (program) and `op_addr`/`op_data` equal to the fourth write. Only address bits 10..0 and data bits 7..0 of command writes are compared; the remaining bits are don't-care.
- R3: Set-up code 40h followed by two address/data writes whose addresses match in every bit above bit 0 produces `op_kind`=2. The first write appears on `op_addr`/`op_data` and the second on `op_addr2`/`op_data2`. Any other difference between the two addresses produces an abort.
- R4: Set-up code 80h, then AAh@555h, then 55h@2AAh, then a sixth write produces `op_kind`=3 (block erase) if its data is 30h, or `op_kind`=4 (bank erase) if its data is 10h. In both cases `op_addr` is the address of the sixth write.
- R5: Set-up code 90h produces `op_kind`=7 and sets `read_mode` to 1. A lone 98h@055h produces `op_kind`=8 and sets `read_mode` to 2. F0h, written alone or directly after the two unlock writes, sets `read_mode` to 0 without an operation.
- R6: A write that breaks the expected sequence produces a one-cycle `abort_pulse`, sets `read_mode` to 0 and clears bypass. A following well-formed instruction is then decoded normally. Unknown set-up codes and F0h after only one unlock write are breaks.
- R7: Set-up code 60h followed by a write with data 03h produces `op_kind`=9 and loads `cfg_word` with address bits 15..0 of that write; `pd_enable` equals bit 10. Any other second data aborts and leaves `cfg_word` unchanged.
- R8: Set-up code 20h produces `op_kind`=10 and sets `in_bypass`. In bypass, A0h at any address followed by one address/data write produces `op_kind`=1. The pair 90h then 00h produces `op_kind`=11 and clears `in_bypass`.
- R9: While `busy` is high, B0h at any address, with no unlock writes, produces `op_kind`=5 (suspend), but only if the last erase issued was a block erase. After a bank erase, B0h is ignored.
- R10: While `busy` is high, every write other than an accepted suspend is ignored: no `op_valid`, no `abort_pulse`, and `read_mode` does not change.
- R11: While `suspended` is high, a lone 30h at an address in the same bank as the suspended erase produces `op_kind`=6 (resume). The lower bank is addresses below `BANK_SPLIT`. A 30h in the other bank aborts.
- R12: While `suspended` is high, the only accepted set-up code is A0h, and any other code aborts. The program is issued only if its address lies outside the erased block (blocks are address bits above `BLK_SHIFT`); otherwise it aborts.
- R13: `op_valid` and `abort_pulse` are never high together, and each is high only in the cycle after a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data of the write |
| busy | input | 1 | Program/erase engine running |
| suspended | input | 1 | Erase on hold |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 4 | Operation code (see requirements) |
| op_addr | output | ADDR_W | Operation address (first word) |
| op_data | output | DATA_W | Operation data (first word) |
| op_addr2 | output | ADDR_W | Second word address of a double-word program |
| op_data2 | output | DATA_W | Second word data of a double-word program |
| abort_pulse | output | 1 | One-cycle sequence abort |
| read_mode | output | 2 | 0 array, 1 identification, 2 query table |
| in_bypass | output | 1 | Unlock bypass active |
| cfg_word | output | 16 | Configuration word |
| pd_enable | output | 1 | Power-down enable (configuration bit 10) |

## Verification
The hardest case to reach from the ports is a program issued while an erase is suspended. Reaching it needs a completed block erase whose block and bank the sequencer has recorded, then an accepted suspend while `busy` is high, then `suspended` raised with `busy` lowered. The bench plays exactly that sequence. It then probes one program inside the recorded block, one outside it, a forbidden set-up code, and resumes aimed at each bank. After that it repeats the erase as a bank erase to show the suspend being refused.

// File: rtl/flash_cmd_seq_pkg.sv
// Package: shared types and command constants of the flash command sequencer.
// Assumes command bytes sit in data bits 7..0 and unlock addresses in bits 10..0.
package flash_cmd_seq_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY   = 2'd0,
        RM_AUTOSEL = 2'd1,
        RM_CFI     = 2'd2
    } rmode_e;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_PROG      = 4'd1,
        OP_DWPROG    = 4'd2,
        OP_BLKERASE  = 4'd3,
        OP_BANKERASE = 4'd4,
        OP_SUSPEND   = 4'd5,
        OP_RESUME    = 4'd6,
        OP_AUTOSEL   = 4'd7,
        OP_CFI       = 4'd8,
        OP_CFGWR     = 4'd9,
        OP_BYP_ENTER = 4'd10,
        OP_BYP_EXIT  = 4'd11
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_U1,
        ST_U2,
        ST_PG,
        ST_DW1,
        ST_DW2,
        ST_ER1,
        ST_ER2,
        ST_ER3,
        ST_CFG,
        ST_BY_IDLE,
        ST_BY_EXIT
    } seq_st_e;

    localparam int CMP_W = 11;
    localparam logic [CMP_W-1:0] ADR_KEY1  = 11'h555;
    localparam logic [CMP_W-1:0] ADR_KEY2  = 11'h2AA;
    localparam logic [CMP_W-1:0] ADR_QUERY = 11'h055;

    localparam logic [7:0] C_KEY1     = 8'hAA;
    localparam logic [7:0] C_KEY2     = 8'h55;
    localparam logic [7:0] C_READ     = 8'hF0;
    localparam logic [7:0] C_QUERY    = 8'h98;
    localparam logic [7:0] C_PROG     = 8'hA0;
    localparam logic [7:0] C_DWPROG   = 8'h40;
    localparam logic [7:0] C_ERSETUP  = 8'h80;
    localparam logic [7:0] C_IDENT    = 8'h90;
    localparam logic [7:0] C_CONFIG   = 8'h60;
    localparam logic [7:0] C_BYPASS   = 8'h20;
    localparam logic [7:0] C_BLKCONF  = 8'h30;
    localparam logic [7:0] C_BANKCONF = 8'h10;
    localparam logic [7:0] C_SUSPEND  = 8'hB0;
    localparam logic [7:0] C_CFGCONF  = 8'h03;
    localparam logic [7:0] C_BYEXIT   = 8'h00;

endpackage

// File: rtl/flash_cmd_seq_match.sv
// Module: address/data pre-decode for command writes.
// Assumes ADDR_W >= CMP_W; compares only the low address bits and the low data byte.
module flash_cmd_seq_match
    import flash_cmd_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [7:0]        cmd,
    output logic              at_key1,
    output logic              at_key2,
    output logic              at_query
);
    logic [CMP_W-1:0] low_addr;

    // Slice out the compared address field and the command byte.
    always_comb begin
        low_addr = addr[CMP_W-1:0];
        cmd      = data[7:0];
        at_key1  = (low_addr == ADR_KEY1);
        at_key2  = (low_addr == ADR_KEY2);
        at_query = (low_addr == ADR_QUERY);
    end
endmodule

// File: rtl/flash_cmd_seq_erase_track.sv
// Module: remembers the last erase issued and judges suspend, resume and
// suspended-program legality. Assumes blocks are aligned on 2**BLK_SHIFT words
// and that addresses at or above BANK_SPLIT form the second bank.
module flash_cmd_seq_erase_track
    import flash_cmd_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int BLK_SHIFT  = 15,
    parameter int BANK_SPLIT = 32'h40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  op_e               issue_kind,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic              suspended,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              suspend_ok,
    output logic              resume_ok,
    output logic              prog_ok
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;
    localparam logic [ADDR_W-1:0] SPLIT_A = ADDR_W'(BANK_SPLIT);

    logic [BLK_W-1:0] er_blk;
    logic             er_bank;
    logic             er_is_bank;
    logic             blk_live;
    logic             probe_bank;
    logic [BLK_W-1:0] probe_blk;

    // Record the region of each erase and whether a block erase is the live one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            er_blk     <= '0;
            er_bank    <= 1'b0;
            er_is_bank <= 1'b0;
            blk_live   <= 1'b0;
        end else if (issue_valid) begin
            if (issue_kind == OP_BLKERASE) begin
                er_blk     <= issue_addr[ADDR_W-1:BLK_SHIFT];
                er_bank    <= (issue_addr >= SPLIT_A);
                er_is_bank <= 1'b0;
                blk_live   <= 1'b1;
            end else if (issue_kind == OP_BANKERASE) begin
                er_bank    <= (issue_addr >= SPLIT_A);
                er_is_bank <= 1'b1;
                blk_live   <= 1'b0;
            end else if ((issue_kind == OP_PROG || issue_kind == OP_DWPROG) && !suspended) begin
                blk_live   <= 1'b0;
            end
        end
    end

    // Judge the current write against the recorded erase region.
    always_comb begin
        probe_bank = (probe_addr >= SPLIT_A);
        probe_blk  = probe_addr[ADDR_W-1:BLK_SHIFT];
        suspend_ok = blk_live && !suspended;
        resume_ok  = suspended && (probe_bank == er_bank);
        if (!suspended)
            prog_ok = 1'b1;
        else if (er_is_bank)
            prog_ok = (probe_bank != er_bank);
        else
            prog_ok = (probe_blk != er_blk);
    end
endmodule

// File: rtl/flash_cmd_seq_cfg.sv
// Module: configuration word storage; loads when the sequencer confirms a write.
// Assumes PD_BIT < CFG_W.
module flash_cmd_seq_cfg #(
    parameter int CFG_W  = 16,
    parameter int PD_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] value,
    output logic [CFG_W-1:0] cfg_q,
    output logic             pd_en
);
    // Hold the configuration word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (load)
            cfg_q <= value;
    end

    // Expose the power-down enable bit.
    always_comb pd_en = cfg_q[PD_BIT];
endmodule

// File: rtl/flash_cmd_seq_grammar.sv
// Module: the command grammar state machine. Consumes pre-decoded writes and
// legality flags, emits a combinational issue for the erase tracker and
// registered operation, abort and mode outputs. Assumes at most one write per cycle.
module flash_cmd_seq_grammar
    import flash_cmd_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [7:0]        cmd,
    input  logic              at_key1,
    input  logic              at_key2,
    input  logic              at_query,
    input  logic              busy,
    input  logic              suspended,
    input  logic              suspend_ok,
    input  logic              resume_ok,
    input  logic              prog_ok,
    output logic              issue_valid,
    output op_e               issue_kind,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              cfg_load,
    output logic [CFG_W-1:0]  cfg_val,
    output logic              op_valid,
    output op_e               op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [ADDR_W-1:0] op_addr2,
    output logic [DATA_W-1:0] op_data2,
    output logic              abort_q,
    output rmode_e            mode_q,
    output logic              byp_q
);
    seq_st_e           st, st_n;
    rmode_e            mode_n;
    logic              byp_n;
    logic              brk;
    logic [ADDR_W-1:0] a1, a1_n, o_addr, o_addr2;
    logic [DATA_W-1:0] d1, d1_n, o_data, o_data2;

    // Next-state decode of one write against the grammar.
    always_comb begin
        st_n       = st;
        mode_n     = mode_q;
        byp_n      = byp_q;
        brk        = 1'b0;
        a1_n       = a1;
        d1_n       = d1;
        issue_valid = 1'b0;
        issue_kind  = OP_NONE;
        cfg_load    = 1'b0;
        cfg_val     = addr[CFG_W-1:0];
        o_addr      = addr;
        o_data      = data;
        o_addr2     = addr;
        o_data2     = data;
        if (stb) begin
            if (busy) begin
                if (cmd == C_SUSPEND && suspend_ok) begin
                    issue_valid = 1'b1;
                    issue_kind  = OP_SUSPEND;
                    st_n        = ST_IDLE;
                    mode_n      = RM_ARRAY;
                    byp_n       = 1'b0;
                end
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (cmd == C_READ)
                            mode_n = RM_ARRAY;
                        else if (cmd == C_KEY1 && at_key1)
                            st_n = ST_U1;
                        else if (cmd == C_QUERY && at_query) begin
                            mode_n      = RM_CFI;
                            issue_valid = 1'b1;
                            issue_kind  = OP_CFI;
                        end else if (cmd == C_BLKCONF && resume_ok) begin
                            mode_n      = RM_ARRAY;
                            issue_valid = 1'b1;
                            issue_kind  = OP_RESUME;
                        end else
                            brk = 1'b1;
                    end
                    ST_U1: begin
                        if (cmd == C_KEY2 && at_key2)
                            st_n = ST_U2;
                        else
                            brk = 1'b1;
                    end
                    ST_U2: begin
                        st_n = ST_IDLE;
                        if (suspended) begin
                            if (cmd == C_PROG && at_key1)
                                st_n = ST_PG;
                            else
                                brk = 1'b1;
                        end else if (cmd == C_READ)
                            mode_n = RM_ARRAY;
                        else if (!at_key1)
                            brk = 1'b1;
                        else begin
                            case (cmd)
                                C_PROG:    st_n = ST_PG;
                                C_DWPROG:  st_n = ST_DW1;
                                C_ERSETUP: st_n = ST_ER1;
                                C_CONFIG:  st_n = ST_CFG;
                                C_IDENT: begin
                                    mode_n      = RM_AUTOSEL;
                                    issue_valid = 1'b1;
                                    issue_kind  = OP_AUTOSEL;
                                end
                                C_BYPASS: begin
                                    byp_n       = 1'b1;
                                    st_n        = ST_BY_IDLE;
                                    mode_n      = RM_ARRAY;
                                    issue_valid = 1'b1;
                                    issue_kind  = OP_BYP_ENTER;
                                end
                                default:   brk = 1'b1;
                            endcase
                        end
                    end
                    ST_PG: begin
                        st_n = byp_q ? ST_BY_IDLE : ST_IDLE;
                        if (prog_ok) begin
                            mode_n      = RM_ARRAY;
                            issue_valid = 1'b1;
                            issue_kind  = OP_PROG;
                        end else
                            brk = 1'b1;
                    end
                    ST_DW1: begin
                        a1_n = addr;
                        d1_n = data;
                        st_n = ST_DW2;
                    end
                    ST_DW2: begin
                        st_n    = ST_IDLE;
                        o_addr  = a1;
                        o_data  = d1;
                        if (addr[ADDR_W-1:1] == a1[ADDR_W-1:1]) begin
                            mode_n      = RM_ARRAY;
                            issue_valid = 1'b1;
                            issue_kind  = OP_DWPROG;
                        end else
                            brk = 1'b1;
                    end
                    ST_ER1: begin
                        if (cmd == C_KEY1 && at_key1)
                            st_n = ST_ER2;
                        else
                            brk = 1'b1;
                    end
                    ST_ER2: begin
                        if (cmd == C_KEY2 && at_key2)
                            st_n = ST_ER3;
                        else
                            brk = 1'b1;
                    end
                    ST_ER3: begin
                        st_n   = ST_IDLE;
                        mode_n = RM_ARRAY;
                        if (cmd == C_BLKCONF) begin
                            issue_valid = 1'b1;
                            issue_kind  = OP_BLKERASE;
                        end else if (cmd == C_BANKCONF) begin
                            issue_valid = 1'b1;
                            issue_kind  = OP_BANKERASE;
                        end else
                            brk = 1'b1;
                    end
                    ST_CFG: begin
                        st_n = ST_IDLE;
                        if (cmd == C_CFGCONF) begin
                            cfg_load    = 1'b1;
                            issue_valid = 1'b1;
                            issue_kind  = OP_CFGWR;
                        end else
                            brk = 1'b1;
                    end
                    ST_BY_IDLE: begin
                        if (cmd == C_PROG)
                            st_n = ST_PG;
                        else if (cmd == C_IDENT)
                            st_n = ST_BY_EXIT;
                        else
                            brk = 1'b1;
                    end
                    ST_BY_EXIT: begin
                        if (cmd == C_BYEXIT) begin
                            st_n        = ST_IDLE;
                            byp_n       = 1'b0;
                            mode_n      = RM_ARRAY;
                            issue_valid = 1'b1;
                            issue_kind  = OP_BYP_EXIT;
                        end else
                            brk = 1'b1;
                    end
                    default: brk = 1'b1;
                endcase
            end
        end
        if (brk) begin
            st_n   = ST_IDLE;
            mode_n = RM_ARRAY;
            byp_n  = 1'b0;
        end
        issue_addr = o_addr;
    end

    // Sequence state, mode, bypass flag and first-word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            mode_q <= RM_ARRAY;
            byp_q  <= 1'b0;
            a1     <= '0;
            d1     <= '0;
        end else begin
            st     <= st_n;
            mode_q <= mode_n;
            byp_q  <= byp_n;
            a1     <= a1_n;
            d1     <= d1_n;
        end
    end

    // Registered operation request and abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
            op_addr2 <= '0;
            op_data2 <= '0;
            abort_q  <= 1'b0;
        end else begin
            op_valid <= issue_valid;
            abort_q  <= brk;
            if (issue_valid) begin
                op_kind  <= issue_kind;
                op_addr  <= o_addr;
                op_data  <= o_data;
                op_addr2 <= o_addr2;
                op_data2 <= o_data2;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
// Module: top of the flash command interface sequencer. Wires the pre-decode,
// grammar, erase tracker and configuration word. Assumes writes arrive already
// synchronized as one-cycle strobes and that ADDR_W >= 16.
module flash_cmd_seq
    import flash_cmd_seq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int BLK_SHIFT  = 15,
    parameter int BANK_SPLIT = 32'h40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              suspended,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [ADDR_W-1:0] op_addr2,
    output logic [DATA_W-1:0] op_data2,
    output logic              abort_pulse,
    output logic [1:0]        read_mode,
    output logic              in_bypass,
    output logic [15:0]       cfg_word,
    output logic              pd_enable
);
    localparam int CFG_W  = 16;
    localparam int PD_BIT = 10;

    logic [7:0]        cmd;
    logic              at_key1, at_key2, at_query;
    logic              suspend_ok, resume_ok, prog_ok;
    logic              issue_valid;
    op_e               issue_kind;
    logic [ADDR_W-1:0] issue_addr;
    logic              cfg_load;
    logic [CFG_W-1:0]  cfg_val;
    op_e               kind_q;
    rmode_e            mode_q;

    flash_cmd_seq_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr(wr_addr), .data(wr_data), .cmd(cmd),
        .at_key1(at_key1), .at_key2(at_key2), .at_query(at_query)
    );

    flash_cmd_seq_erase_track #(
        .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .BANK_SPLIT(BANK_SPLIT)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_kind(issue_kind), .issue_addr(issue_addr),
        .suspended(suspended), .probe_addr(wr_addr),
        .suspend_ok(suspend_ok), .resume_ok(resume_ok), .prog_ok(prog_ok)
    );

    flash_cmd_seq_grammar #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_gram (
        .clk(clk), .rst_n(rst_n),
        .stb(wr_stb), .addr(wr_addr), .data(wr_data), .cmd(cmd),
        .at_key1(at_key1), .at_key2(at_key2), .at_query(at_query),
        .busy(busy), .suspended(suspended),
        .suspend_ok(suspend_ok), .resume_ok(resume_ok), .prog_ok(prog_ok),
        .issue_valid(issue_valid), .issue_kind(issue_kind), .issue_addr(issue_addr),
        .cfg_load(cfg_load), .cfg_val(cfg_val),
        .op_valid(op_valid), .op_kind(kind_q),
        .op_addr(op_addr), .op_data(op_data),
        .op_addr2(op_addr2), .op_data2(op_data2),
        .abort_q(abort_pulse), .mode_q(mode_q), .byp_q(in_bypass)
    );

    flash_cmd_seq_cfg #(.CFG_W(CFG_W), .PD_BIT(PD_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .value(cfg_val),
        .cfg_q(cfg_word), .pd_en(pd_enable)
    );

    // Present enum-typed state on plain-vector ports.
    always_comb begin
        op_kind   = kind_q;
        read_mode = mode_q;
    end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
// Module: property checker for the command sequencer, bound onto the top.
// Assumes the same parameter values as the instance it is bound to.
module flash_cmd_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              busy,
    input logic              op_valid,
    input logic [3:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic [DATA_W-1:0] op_data,
    input logic [ADDR_W-1:0] op_addr2,
    input logic              abort_pulse,
    input logic [1:0]        read_mode,
    input logic              in_bypass,
    input logic [15:0]       cfg_word
);
    assert_op_abort_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && abort_pulse));

    assert_out_follows_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid || abort_pulse) |-> $past(wr_stb));

    assert_busy_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_stb && wr_data[7:0] != 8'hB0) |=> (!op_valid && !abort_pulse));

    assert_prog_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd1) |-> (op_addr == $past(wr_addr) && op_data == $past(wr_data)));

    assert_dw_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd2) |-> (op_addr[ADDR_W-1:1] == op_addr2[ADDR_W-1:1]));

    assert_cfg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd9) |-> (cfg_word == $past(wr_addr[15:0])));

    assert_bypass_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd10) |-> in_bypass);

    assert_bypass_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd11) |-> !in_bypass);

    assert_abort_array_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> (read_mode == 2'd0 && !in_bypass));

    assert_ident_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 4'd7) |-> (read_mode == 2'd1));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .op_addr2(op_addr2), .abort_pulse(abort_pulse),
    .read_mode(read_mode), .in_bypass(in_bypass), .cfg_word(cfg_word)
);

// File: tb/flash_cmd_seq_bench.sv
// Directed bench for the flash command sequencer: one task per scenario.
module flash_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        suspended = 1'b0;
    logic        op_valid;
    logic [3:0]  op_kind;
    logic [19:0] op_addr, op_addr2;
    logic [15:0] op_data, op_data2;
    logic        abort_pulse;
    logic [1:0]  read_mode;
    logic        in_bypass;
    logic [15:0] cfg_word;
    logic        pd_enable;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .suspended(suspended), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_addr2(op_addr2), .op_data2(op_data2),
        .abort_pulse(abort_pulse), .read_mode(read_mode), .in_bypass(in_bypass),
        .cfg_word(cfg_word), .pd_enable(pd_enable)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One write; returns at the negedge after capture, when registered outputs show it.
    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb  = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic unlock();
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0055);
    endtask

    task automatic expect_op(input string tag, input int kind);
        chk({tag, " op_valid"}, op_valid, 1);
        chk({tag, " op_kind"}, op_kind, kind);
        chk({tag, " no abort"}, abort_pulse, 0);
    endtask

    task automatic expect_abort(input string tag);
        chk({tag, " abort"}, abort_pulse, 1);
        chk({tag, " no op"}, op_valid, 0);
        chk({tag, " mode array"}, read_mode, 0);
    endtask

    task automatic t_reset();
        chk("R1 mode", read_mode, 0);
        chk("R1 bypass", in_bypass, 0);
        chk("R1 cfg", cfg_word, 0);
        chk("R1 op", op_valid, 0);
        chk("R1 abort", abort_pulse, 0);
    endtask

    task automatic t_program();
        wr(20'hF0555, 16'hC3AA);
        chk("R2 no op mid-sequence", op_valid, 0);
        wr(20'hAB2AA, 16'h0055);
        wr(20'h7F555, 16'h00A0);
        wr(20'h12345, 16'hBEEF);
        expect_op("R2 program", 1);
        chk("R2 addr", op_addr, 20'h12345);
        chk("R2 data", op_data, 16'hBEEF);
    endtask

    task automatic t_dword();
        unlock();
        wr(20'h00555, 16'h0040);
        wr(20'h00100, 16'h1111);
        wr(20'h00101, 16'h2222);
        expect_op("R3 dword", 2);
        chk("R3 addr1", op_addr, 20'h00100);
        chk("R3 data1", op_data, 16'h1111);
        chk("R3 addr2", op_addr2, 20'h00101);
        chk("R3 data2", op_data2, 16'h2222);
        unlock();
        wr(20'h00555, 16'h0040);
        wr(20'h00100, 16'h3333);
        wr(20'h00103, 16'h4444);
        expect_abort("R3 dword bad pair");
    endtask

    task automatic erase_seq(input logic [19:0] a, input logic [15:0] conf);
        unlock();
        wr(20'h00555, 16'h0080);
        unlock();
        wr(a, conf);
    endtask

    task automatic t_erase();
        erase_seq(20'h08000, 16'h0030);
        expect_op("R4 block erase", 3);
        chk("R4 block addr", op_addr, 20'h08000);
        erase_seq(20'h50000, 16'h0010);
        expect_op("R4 bank erase", 4);
        chk("R4 bank addr", op_addr, 20'h50000);
    endtask

    task automatic t_modes();
        unlock();
        wr(20'h00555, 16'h0090);
        expect_op("R5 ident", 7);
        chk("R5 ident mode", read_mode, 1);
        wr(20'h00000, 16'h00F0);
        chk("R5 F0 alone mode", read_mode, 0);
        chk("R5 F0 alone no op", op_valid, 0);
        wr(20'h00055, 16'h0098);
        expect_op("R5 query", 8);
        chk("R5 query mode", read_mode, 2);
        unlock();
        wr(20'h00123, 16'h00F0);
        chk("R5 F0 after unlock mode", read_mode, 0);
        chk("R5 F0 after unlock no abort", abort_pulse, 0);
    endtask

    task automatic t_abort();
        wr(20'h00055, 16'h0098);
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0056);
        expect_abort("R6 bad second key");
        unlock();
        wr(20'h00555, 16'h0077);
        expect_abort("R6 unknown setup");
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h00F0);
        expect_abort("R6 F0 after one key");
        unlock();
        wr(20'h00555, 16'h00A0);
        wr(20'h00042, 16'h5A5A);
        expect_op("R6 recovers", 1);
    endtask

    task automatic t_cfg();
        unlock();
        wr(20'h00555, 16'h0060);
        wr(20'h00400, 16'h0003);
        expect_op("R7 cfg", 9);
        chk("R7 cfg word", cfg_word, 16'h0400);
        chk("R7 pd on", pd_enable, 1);
        unlock();
        wr(20'h00555, 16'h0060);
        wr(20'h31234, 16'h0003);
        chk("R7 cfg word 2", cfg_word, 16'h1234);
        chk("R7 pd off", pd_enable, 0);
        unlock();
        wr(20'h00555, 16'h0060);
        wr(20'h0FFFF, 16'h0004);
        expect_abort("R7 bad confirm");
        chk("R7 cfg kept", cfg_word, 16'h1234);
    endtask

    task automatic t_bypass();
        unlock();
        wr(20'h00555, 16'h0020);
        expect_op("R8 enter", 10);
        chk("R8 in bypass", in_bypass, 1);
        wr(20'h07777, 16'h00A0);
        wr(20'h33333, 16'h0F0F);
        expect_op("R8 bypass program", 1);
        chk("R8 bypass addr", op_addr, 20'h33333);
        chk("R8 still bypass", in_bypass, 1);
        wr(20'h00000, 16'h0090);
        wr(20'h00000, 16'h0000);
        expect_op("R8 exit", 11);
        chk("R8 bypass cleared", in_bypass, 0);
    endtask

    task automatic t_busy_ignore();
        wr(20'h00055, 16'h0098);
        busy = 1'b1;
        wr(20'h00000, 16'h00F0);
        chk("R10 F0 ignored op", op_valid, 0);
        chk("R10 F0 ignored abort", abort_pulse, 0);
        chk("R10 mode kept", read_mode, 2);
        wr(20'h00555, 16'h00AA);
        chk("R10 key ignored abort", abort_pulse, 0);
        busy = 1'b0;
        wr(20'h00000, 16'h00F0);
        chk("R10 F0 after busy", read_mode, 0);
    endtask

    task automatic t_suspend();
        erase_seq(20'h08000, 16'h0030);
        expect_op("R9 start block erase", 3);
        busy = 1'b1;
        wr(20'h99999, 16'h00B0);
        expect_op("R9 suspend", 5);
        busy = 1'b0;
        suspended = 1'b1;
        unlock();
        wr(20'h00555, 16'h00A0);
        wr(20'h10000, 16'h1234);
        expect_op("R12 program other block", 1);
        unlock();
        wr(20'h00555, 16'h00A0);
        wr(20'h08010, 16'h1234);
        expect_abort("R12 program erased block");
        unlock();
        wr(20'h00555, 16'h0080);
        expect_abort("R12 setup not allowed");
        wr(20'h50000, 16'h0030);
        expect_abort("R11 resume wrong bank");
        wr(20'h20000, 16'h0030);
        expect_op("R11 resume", 6);
        suspended = 1'b0;
        erase_seq(20'h50000, 16'h0010);
        expect_op("R9 start bank erase", 4);
        busy = 1'b1;
        wr(20'h50000, 16'h00B0);
        chk("R9 suspend refused op", op_valid, 0);
        chk("R9 suspend refused abort", abort_pulse, 0);
        busy = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_dword();
        t_erase();
        t_modes();
        t_abort();
        t_cfg();
        t_bypass();
        t_busy_ignore();
        t_suspend();
        repeat (3) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule